// File: doc/BRIEF.md
# Regional pixel histogram engine

The engine builds intensity histograms over a stream of raw sensor pixels, one histogram for each of four rectangular windows. Every accepted pixel is multiplied by a white-balance gain picked from its colour phase, clipped at full scale, and shifted right to a bin number. The matching counter in each window's histogram is then incremented.

Software configures the block and collects results through a small register port. A pointer register picks the first word to fetch, and each read of the data register returns one counter and moves the pointer on by one. If the clear-on-read control bit is set, each word it returns is also zeroed, so a readout pass leaves the memory clean for the next accumulation. A read that meets a pixel increment to the same word waits one cycle, so the increment is never lost.

Top module: `hist_region_engine`

## Requirements
- R1: After reset, `reg_rvalid` is low and every histogram word reads back as zero.
- R2: A pixel counts in window r only if its column c satisfies hstart <= c <= hend and its row y satisfies vstart <= y <= vend, both bounds inclusive. Columns count accepted pixels from 0. A pixel with `pix_eol` set ends its line (next column 0, next row +1). A pixel with `pix_eof` set ends its frame (next column 0, next row 0).
- R3: A window whose horizontal and vertical registers are both zero never counts anything, not even the pixel at column 0, row 0.
- R4: Windows that overlap each count a pixel that lies in both of them, independently.
- R5: The scaled sample is min(floor(pixel * gain / 32), 2^PIX_W - 1), since gains carry 5 fractional bits. The bin is (scaled >> shift) AND (bins - 1).
- R6: With the colour mode bit at 0 (2x2 mosaic), the gain index is 2*(row mod 2) + (column mod 2). With it at 1 (three-colour), the index is column mod 3, and gain 3 is unused.
- R7: Control bits [5:4] select 256, 128, 64 or 32 bins for the values 0, 1, 2 or 3. Window r, bin b is stored at word r*bins + b.
- R8: Register addresses are: 0 control, 1 gains, 2 pointer, 3 data. Addresses 4+r hold window r horizontally as start in [15:0] and end in [31:16]. Addresses 8+r hold window r vertically in the same layout. Gain i is held in bits [8i+7:8i]. A write to address 2 loads the pointer. Each read of address 3 returns the word at the pointer with `reg_rvalid` high one cycle later, and advances the pointer by one.
- R9: While control bit 1 is set, each word returned by a data read is zeroed in memory. While it is clear, reads leave the memory unchanged.
- R10: Each bin is a saturating counter of BIN_W bits. It stops at 2^BIN_W - 1 and never wraps.
- R11: If a data read targets the word that a pixel increments in the same cycle, the increment is applied first. The read completes one cycle later and returns the incremented value.
- R12: Control bit 0 enables accumulation. Pixels that arrive while it is 0 change no bin. Bits [11:8] of the control register hold the shift, and bit 2 holds the colour mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Pixel present this cycle |
| pix_data | input | PIX_W | Raw pixel value |
| pix_eol | input | 1 | Marks the last pixel of a line |
| pix_eof | input | 1 | Marks the last pixel of a frame |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (data register) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data returned |

## Verification
The bench builds the engine with 8-bit pixels, 8-bit coordinates and 4-bit bins. With 8-bit pixels, shifts of 0 to 3 map exactly onto the four bin counts, and the gain clip is easy to reach with a gain of 2.0. With 4-bit bins, the saturation limit falls within twenty tiny frames instead of a million pixels. A single-pixel frame followed at once by a clearing read of that pixel's word exercises the one-cycle read stall.

// File: rtl/hist_region_engine.sv
module hist_region_engine #(
  parameter int PIX_W   = 10,
  parameter int BIN_W   = 20,
  parameter int COORD_W = 12,
  parameter int GAIN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_valid,
  input  logic [PIX_W-1:0]  pix_data,
  input  logic              pix_eol,
  input  logic              pix_eof,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              reg_rvalid
);
  localparam int NREG  = 4;
  localparam int NBIN  = 256;
  localparam int GFRAC = 5;
  localparam int PW    = $clog2(NREG * NBIN);
  localparam int PRW   = PIX_W + GAIN_W;
  localparam logic [BIN_W-1:0] CMAX = '1;
  localparam logic [3:0] A_CTRL = 4'd0, A_GAIN = 4'd1, A_PTR = 4'd2, A_DATA = 4'd3;

  logic              ctrl_en, ctrl_clr, ctrl_cfa;
  logic [1:0]        ctrl_bsel;
  logic [3:0]        ctrl_shift;
  logic [GAIN_W-1:0] gain [NREG];
  logic [COORD_W-1:0] hs [NREG], he [NREG], vs [NREG], ve [NREG];
  logic [NREG-1:0]   used, hit;

  logic [COORD_W-1:0] col, row;
  logic [1:0]         ph3, gsel;

  logic               s1_v;
  logic [PIX_W-1:0]   s1_pix;
  logic [GAIN_W-1:0]  s1_gain;
  logic [COORD_W-1:0] s1_col, s1_row;

  logic [PRW-1:0]     prod, shp;
  logic [PIX_W-1:0]   scaled;
  logic [7:0]         mask, bin, rword;
  logic [3:0]         lg;
  logic [1:0]         rbank;
  logic [PW-1:0]      ptr;
  logic               ptr_wr, rd_req, rd_pend, rd_go, collide, fire;

  logic [BIN_W-1:0]   mem [NREG][NBIN];

  assign gsel   = ctrl_cfa ? ph3 : {row[0], col[0]};
  assign prod   = PRW'(s1_pix) * PRW'(s1_gain);
  assign shp    = prod >> GFRAC;
  assign scaled = (|shp[PRW-1:PIX_W]) ? '1 : shp[PIX_W-1:0];
  assign mask   = 8'hFF >> ctrl_bsel;
  assign bin    = 8'(scaled >> ctrl_shift) & mask;

  for (genvar r = 0; r < NREG; r++) begin : g_win
    assign used[r] = |{hs[r], he[r], vs[r], ve[r]};
    assign hit[r]  = s1_v && used[r] &&
                     (s1_col >= hs[r]) && (s1_col <= he[r]) &&
                     (s1_row >= vs[r]) && (s1_row <= ve[r]);
  end

  assign lg      = 4'd8 - {2'b00, ctrl_bsel};
  assign rbank   = 2'(ptr >> lg);
  assign rword   = 8'(ptr) & mask;
  assign ptr_wr  = reg_wr && (reg_addr == A_PTR);
  assign rd_req  = reg_rd && (reg_addr == A_DATA);
  assign rd_go   = rd_req || rd_pend;
  assign collide = hit[rbank] && (bin == rword);
  assign fire    = rd_go && !collide;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col <= '0; row <= '0; ph3 <= '0;
    end else if (pix_valid) begin
      if (pix_eof) begin
        col <= '0; row <= '0; ph3 <= '0;
      end else if (pix_eol) begin
        col <= '0; row <= row + 1'b1; ph3 <= '0;
      end else begin
        col <= col + 1'b1;
        ph3 <= (ph3 == 2'd2) ? 2'd0 : ph3 + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s1_pix <= '0; s1_gain <= '0; s1_col <= '0; s1_row <= '0;
    end else begin
      s1_v <= pix_valid && ctrl_en;
      if (pix_valid) begin
        s1_pix  <= pix_data;
        s1_gain <= gain[gsel];
        s1_col  <= col;
        s1_row  <= row;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en <= 1'b0; ctrl_clr <= 1'b0; ctrl_cfa <= 1'b0;
      ctrl_bsel <= '0; ctrl_shift <= '0;
      for (int r = 0; r < NREG; r++) begin
        gain[r] <= '0; hs[r] <= '0; he[r] <= '0; vs[r] <= '0; ve[r] <= '0;
      end
    end else if (reg_wr) begin
      if (reg_addr == A_CTRL) begin
        ctrl_en    <= reg_wdata[0];
        ctrl_clr   <= reg_wdata[1];
        ctrl_cfa   <= reg_wdata[2];
        ctrl_bsel  <= reg_wdata[5:4];
        ctrl_shift <= reg_wdata[11:8];
      end
      if (reg_addr == A_GAIN)
        for (int i = 0; i < NREG; i++) gain[i] <= reg_wdata[8*i +: GAIN_W];
      if (reg_addr[3:2] == 2'b01) begin
        hs[reg_addr[1:0]] <= reg_wdata[COORD_W-1:0];
        he[reg_addr[1:0]] <= reg_wdata[16 +: COORD_W];
      end
      if (reg_addr[3:2] == 2'b10) begin
        vs[reg_addr[1:0]] <= reg_wdata[COORD_W-1:0];
        ve[reg_addr[1:0]] <= reg_wdata[16 +: COORD_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0; rd_pend <= 1'b0; reg_rvalid <= 1'b0; reg_rdata <= '0;
      for (int r = 0; r < NREG; r++)
        for (int w = 0; w < NBIN; w++) mem[r][w] <= '0;
    end else begin
      rd_pend    <= rd_go && collide;
      reg_rvalid <= fire;
      if (fire) begin
        reg_rdata <= 32'(mem[rbank][rword]);
        ptr       <= ptr + 1'b1;
        if (ctrl_clr) mem[rbank][rword] <= '0;
      end
      if (ptr_wr) ptr <= reg_wdata[PW-1:0];
      for (int r = 0; r < NREG; r++)
        if (hit[r] && (mem[r][bin] != CMAX)) mem[r][bin] <= mem[r][bin] + 1'b1;
    end
  end
endmodule

// File: rtl/hist_region_engine_chk.sv
module hist_region_engine_chk #(
  parameter int PW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rvalid,
  input logic [PW-1:0] ptr,
  input logic          ptr_wr,
  input logic          rd_req,
  input logic          rd_pend,
  input logic          collide,
  input logic          s1_v,
  input logic          ctrl_en
);
  a_r8_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid && !$past(ptr_wr) |-> ptr == $past(ptr) + 1'b1);

  a_r8_rvalid_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> $past(rd_req || rd_pend));

  a_r11_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req || rd_pend) && collide |=> rd_pend && !rvalid);

  a_r11_resume: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pend && !collide |=> rvalid && !rd_pend);

  a_r12_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |=> !s1_v);
endmodule

bind hist_region_engine hist_region_engine_chk #(.PW(PW)) chk_i (
  .clk(clk), .rst_n(rst_n), .rvalid(reg_rvalid), .ptr(ptr), .ptr_wr(ptr_wr),
  .rd_req(rd_req), .rd_pend(rd_pend), .collide(collide), .s1_v(s1_v),
  .ctrl_en(ctrl_en)
);

// File: tb/hist_region_engine_tb_top.sv
module hist_region_engine_tb_top;
  localparam int P_PIX = 8, P_BIN = 4, P_CRD = 8, P_GAIN = 8;
  localparam int FULL = (1 << P_PIX) - 1;
  localparam int CMAX = (1 << P_BIN) - 1;

  logic clk = 0, rst_n = 0;
  logic pix_valid = 0, pix_eol = 0, pix_eof = 0;
  logic [P_PIX-1:0] pix_data = '0;
  logic reg_wr = 0, reg_rd = 0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic reg_rvalid;

  always #10 clk = ~clk;

  hist_region_engine #(.PIX_W(P_PIX), .BIN_W(P_BIN), .COORD_W(P_CRD), .GAIN_W(P_GAIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
    .pix_eol(pix_eol), .pix_eof(pix_eof), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid));

  int checks = 0, errors = 0;
  int m_mem [4][256];
  int hs [4], he [4], vs [4], ve [4], g [4];
  int b_en = 0, b_clr = 0, b_cfa = 0, b_sel = 0, b_shift = 0, b_ptr = 0;
  int m_col = 0, m_row = 0, m_ph = 0;
  int q_exp [$];
  string q_tag [$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && reg_rvalid) begin
      if (q_exp.size() == 0) chk(1'b0, "R8 unexpected read data", int'(reg_rdata), -1);
      else begin
        int e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        chk(int'(reg_rdata) == e, t, int'(reg_rdata), e);
      end
    end
  end

  task automatic wr_reg(input int a, input int d);
    reg_addr = 4'(a); reg_wdata = 32'(d); reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic wr_ctrl();
    wr_reg(0, (b_shift << 8) | (b_sel << 4) | (b_cfa << 2) | (b_clr << 1) | b_en);
  endtask

  task automatic set_gains(input int a, input int b, input int c, input int d);
    g[0] = a; g[1] = b; g[2] = c; g[3] = d;
    wr_reg(1, a | (b << 8) | (c << 16) | (d << 24));
  endtask

  task automatic set_win(input int r, input int h0, input int h1, input int v0, input int v1);
    hs[r] = h0; he[r] = h1; vs[r] = v0; ve[r] = v1;
    wr_reg(4 + r, h0 | (h1 << 16));
    wr_reg(8 + r, v0 | (v1 << 16));
  endtask

  task automatic set_ptr(input int p);
    b_ptr = p;
    wr_reg(2, p);
  endtask

  task automatic send_pix(input int v, input bit eol, input bit eof);
    pix_valid = 1; pix_data = P_PIX'(v); pix_eol = eol; pix_eof = eof;
    if (b_en != 0) begin
      int gi, sc, bn;
      gi = (b_cfa != 0) ? m_ph : (m_row % 2) * 2 + (m_col % 2);
      sc = (v * g[gi]) >> 5;
      if (sc > FULL) sc = FULL;
      bn = (sc >> b_shift) & ((256 >> b_sel) - 1);
      for (int r = 0; r < 4; r++) begin
        bit used;
        used = (hs[r] | he[r] | vs[r] | ve[r]) != 0;
        if (used && m_col >= hs[r] && m_col <= he[r] && m_row >= vs[r] && m_row <= ve[r]
            && m_mem[r][bn] < CMAX)
          m_mem[r][bn]++;
      end
    end
    if (eof) begin m_col = 0; m_row = 0; m_ph = 0; end
    else if (eol) begin m_col = 0; m_row++; m_ph = 0; end
    else begin m_col++; m_ph = (m_ph == 2) ? 0 : m_ph + 1; end
    @(negedge clk);
  endtask

  task automatic pix_idle();
    pix_valid = 0; pix_eol = 0; pix_eof = 0;
  endtask

  task automatic frame(input int w, input int h, input int kind, input int cval);
    for (int y = 0; y < h; y++)
      for (int x = 0; x < w; x++) begin
        int v;
        v = (kind == 0) ? ((x * 29 + y * 53 + 7) & 255) :
            (kind == 1) ? ((x * 37 + y * 11 + 90) & 255) : cval;
        send_pix(v, x == w - 1, (x == w - 1) && (y == h - 1));
      end
    pix_idle();
    repeat (3) @(negedge clk);
  endtask

  task automatic read_one(input string tag);
    int lg, bank, word;
    lg = 8 - b_sel;
    bank = (b_ptr >> lg) & 3;
    word = b_ptr & ((256 >> b_sel) - 1);
    q_exp.push_back(m_mem[bank][word]);
    q_tag.push_back(tag);
    if (b_clr != 0) m_mem[bank][word] = 0;
    b_ptr = (b_ptr + 1) & 1023;
    reg_addr = 4'd3; reg_rd = 1;
    @(negedge clk);
    reg_rd = 0;
    while (!reg_rvalid) @(negedge clk);
  endtask

  task automatic read_range(input int start, input int n, input string tag);
    set_ptr(start);
    for (int i = 0; i < n; i++) read_one(tag);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    for (int r = 0; r < 4; r++) begin
      hs[r] = 0; he[r] = 0; vs[r] = 0; ve[r] = 0; g[r] = 0;
      for (int w = 0; w < 256; w++) m_mem[r][w] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(reg_rvalid == 1'b0, "R1 rvalid after reset", int'(reg_rvalid), 0);
    read_range(0, 16, "R1 reset bins");

    b_en = 1; b_clr = 1; b_cfa = 0; b_sel = 0; b_shift = 0;
    wr_ctrl();
    set_gains(32, 32, 32, 32);
    set_win(0, 2, 5, 1, 3);
    set_win(1, 0, 7, 0, 7);
    set_win(3, 6, 6, 0, 7);
    frame(8, 8, 0, 0);
    read_range(0, 1024, "R2,R3,R4,R5,R7,R8 window counts");
    b_clr = 0; wr_ctrl();
    read_range(0, 1024, "R9 cleared after clearing pass");

    b_clr = 1; b_sel = 3; b_shift = 3; wr_ctrl();
    set_gains(16, 64, 40, 255);
    set_win(0, 0, 7, 0, 3);
    set_win(1, 1, 3, 2, 3);
    set_win(3, 0, 0, 0, 0);
    frame(8, 4, 1, 0);
    read_range(0, 128, "R5,R6,R7 mosaic gains 32 bins");

    b_clr = 0; b_cfa = 1; b_sel = 2; b_shift = 2; wr_ctrl();
    set_gains(32, 48, 80, 255);
    frame(9, 3, 0, 0);
    read_range(0, 256, "R6,R9 three-colour non-destructive");
    b_clr = 1; wr_ctrl();
    read_range(0, 256, "R9 clearing read");
    b_clr = 0; wr_ctrl();
    read_range(0, 256, "R9 zero after clear");

    b_en = 0; wr_ctrl();
    frame(8, 8, 0, 0);
    read_range(0, 256, "R12 disabled frame");

    b_en = 1; b_clr = 1; b_cfa = 0; b_sel = 0; b_shift = 0; wr_ctrl();
    set_gains(32, 32, 32, 32);
    set_win(0, 0, 1, 0, 0);
    set_win(1, 0, 0, 0, 0);
    for (int f = 0; f < 20; f++) frame(2, 1, 2, 100);
    read_range(99, 3, "R10 saturation");

    frame(1, 1, 2, 50);
    frame(1, 1, 2, 50);
    set_ptr(50);
    send_pix(50, 1'b1, 1'b1);
    pix_idle();
    read_one("R11 read meets increment");
    @(negedge clk);
    read_range(50, 1, "R11 cleared after stalled read");

    repeat (5) @(negedge clk);
    chk(q_exp.size() == 0, "R8 all reads returned", q_exp.size(), 0);
    finish_run();
  end
endmodule